// File: doc/BRIEF.md
# Receive Mode-Code Descriptor Control Register

This block keeps one 16-bit control word that governs how a remote terminal on a MIL-STD-1553 bus handles receive mode-code commands. It applies to commands with the transmit/receive flag at 0 and a subaddress of all zeros or all ones. The host sets the interrupt enables and its own option bits through a single-word read/write port, which is already address-decoded. The device side reports command completions. On each completion the block updates four status bits, which the host cannot write, and decides whether the command raises an "accessed" interrupt or an "index reached zero" interrupt.

Write permission is set per bit and depends on whether terminal execution is enabled. A master reset clears the whole word. A software reset clears only three of the status bits. The "accessed" status bit clears itself after any host read. A raised interrupt sets a sticky pending bit and drives the message-interrupt pin. It also produces a one-cycle log strobe with a 2-bit event code, to be stored outside this block.

Top module: `mcd_ctrl_reg`

## Requirements
- R1: Master reset (`rst_n` low, asynchronous) clears the control word, the pending bits, the interrupt pin and the log strobe to 0.
- R2: A device completion (`dev_done`) qualifies only when `dev_tr` is 0 and `dev_sa` is all zeros or all ones. Any other completion leaves the word unchanged and produces no log strobe.
- R3: Host writes never change bits 11..8. On a qualifying completion, bit 11 (accessed) is set, bit 10 takes `dev_dpb`, bit 9 takes `dev_bcast`, and bit 8 takes the index-zero condition.
- R4: Bits 15..12 and bit 3 take host write data at any time. Bit 2 takes host write data only while `exec_en` is 0. Bits 7..4, 1 and 0 always read 0.
- R5: `sw_rst` clears bits 11, 10 and 9 on the next edge and leaves every other bit of the word unchanged.
- R6: During a host read cycle `host_rdata` shows the current word, including bit 11. After that edge bit 11 is 0.
- R7: If a qualifying completion and a host read occur in the same cycle, bit 11 ends at 1.
- R8: A qualifying completion with word bit 14 and `glob_iwa_en` both 1 sets pending bit 0 on the next edge. It also pulses `log_wr` for one cycle with `log_code[0]`=1.
- R9: A qualifying completion with word bit 15, `glob_ixeqz_en` and `dev_indexed` all 1, `dev_idx_pre`=1 and `dev_idx_post`=0 sets pending bit 1 and `log_code[1]`. Any other index pair (2 to 1, 0 to 0) does not.
- R10: Pending bits stay set until `pend_clr_wr` writes a 1 to them. A set in the same cycle beats the clear. `irq_msg` is high exactly while any pending bit is 1.
- R11: While `exec_en` is 0, completions change no status bit and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| exec_en | input | 1 | Terminal execution enabled |
| sw_rst | input | 1 | Software reset pulse |
| host_rd | input | 1 | Host read cycle to the word |
| host_wr | input | 1 | Host write cycle to the word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Current control word |
| dev_done | input | 1 | Command processing complete pulse |
| dev_tr | input | 1 | Transmit/receive flag of the command |
| dev_sa | input | SA_W | Subaddress of the command |
| dev_indexed | input | 1 | Command used indexed buffering |
| dev_idx_pre | input | IDX_W | Index value before the command |
| dev_idx_post | input | IDX_W | Index value after the command |
| dev_dpb | input | 1 | Buffer status reported by the device |
| dev_bcast | input | 1 | Command was a broadcast |
| glob_iwa_en | input | 1 | Global enable for accessed interrupts |
| glob_ixeqz_en | input | 1 | Global enable for index-zero interrupts |
| pend_clr_wr | input | 1 | Write-one-to-clear strobe for pending bits |
| pend_clr_mask | input | 2 | Pending bits to clear |
| pend_q | output | 2 | Pending interrupts (bit 0 accessed, bit 1 index zero) |
| irq_msg | output | 1 | Message interrupt pin |
| log_wr | output | 1 | Log write strobe |
| log_code | output | 2 | Events in this log entry |

## Verification
The bench targets the collisions between writers. A completion and a read in the same cycle would lose the accessed event if the clear were given priority. A pending set together with a clear would drop a fresh interrupt if the clear won. A software reset that cleared too much would also wipe the index-zero flag or the host bits. The bench toggles `exec_en` around host writes to bit 2, and a gate keyed to the wrong state would lock or free that bit at the wrong time. Index pairs 2 to 1, 1 to 0 and 0 to 0 separate a true falling-to-zero detector from one that only tests whether the new index is zero. Off-subaddress and transmit commands show whether the qualification decode is too loose.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   localparam int WORD_W    = 16;
   localparam int POS_IXQ   = 15;
   localparam int POS_ACC   = 14;
   localparam int POS_DBAC  = 11;
   localparam int POS_DPB   = 10;
   localparam int POS_BCAST = 9;
   localparam int POS_IDXZ  = 8;
   localparam int NUM_EVT   = 2;
   localparam int EVT_ACC   = 0;
   localparam int EVT_IXQ   = 1;

   typedef enum logic [1:0] {
      OWN_NONE,
      OWN_HOST_ANY,
      OWN_HOST_IDLE,
      OWN_DEVICE
   } own_e;

   function automatic own_e bit_owner(input int idx);
      if (idx >= 12)              return OWN_HOST_ANY;
      if (idx == 3)               return OWN_HOST_ANY;
      if (idx == 2)               return OWN_HOST_IDLE;
      if (idx >= 8 && idx <= 11)  return OWN_DEVICE;
      return OWN_NONE;
   endfunction

endpackage

// File: rtl/mcd_host_field.sv
module mcd_host_field
   import mcd_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         exec_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam own_e OWNER = bit_owner(i);
      logic en;

      if (OWNER == OWN_HOST_ANY) begin : g_any
         assign en = wr_en;
      end else if (OWNER == OWN_HOST_IDLE) begin : g_idle
         assign en = wr_en & ~exec_en;
      end else begin : g_none
         assign en = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q[i] <= 1'b0;
         else if (en) q[i] <= wdata[i];
      end
   end

endmodule

// File: rtl/mcd_dev_status.sv
module mcd_dev_status (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic hit,
   input  logic host_rd,
   input  logic dpb_in,
   input  logic bcast_in,
   input  logic idxz_in,
   output logic dbac,
   output logic dpb,
   output logic bcast,
   output logic idxz
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbac  <= 1'b0;
         dpb   <= 1'b0;
         bcast <= 1'b0;
         idxz  <= 1'b0;
      end else if (sw_rst) begin
         dbac  <= 1'b0;
         dpb   <= 1'b0;
         bcast <= 1'b0;
      end else if (hit) begin
         dbac  <= 1'b1;
         dpb   <= dpb_in;
         bcast <= bcast_in;
         idxz  <= idxz_in;
      end else if (host_rd) begin
         dbac  <= 1'b0;
      end
   end

endmodule

// File: rtl/mcd_irq_qual.sv
module mcd_irq_qual
   import mcd_pkg::*;
#(
   parameter int NEV = NUM_EVT
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_hit,
   input  logic [NEV-1:0] word_en,
   input  logic [NEV-1:0] glob_en,
   input  logic [NEV-1:0] cond,
   input  logic           clr_wr,
   input  logic [NEV-1:0] clr_mask,
   output logic [NEV-1:0] pend,
   output logic           irq,
   output logic           log_wr,
   output logic [NEV-1:0] log_code
);

   logic [NEV-1:0] raise;

   assign raise = {NEV{cmd_hit}} & word_en & glob_en & cond;

   for (genvar e = 0; e < NEV; e++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     pend[e] <= 1'b0;
         else if (raise[e])              pend[e] <= 1'b1;
         else if (clr_wr && clr_mask[e]) pend[e] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_wr   <= 1'b0;
         log_code <= '0;
      end else begin
         log_wr   <= |raise;
         log_code <= raise;
      end
   end

   assign irq = |pend;

endmodule

// File: rtl/mcd_ctrl_reg.sv
module mcd_ctrl_reg
   import mcd_pkg::*;
#(
   parameter int SA_W  = 5,
   parameter int IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic              sw_rst,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   input  logic              dev_done,
   input  logic              dev_tr,
   input  logic [SA_W-1:0]   dev_sa,
   input  logic              dev_indexed,
   input  logic [IDX_W-1:0]  dev_idx_pre,
   input  logic [IDX_W-1:0]  dev_idx_post,
   input  logic              dev_dpb,
   input  logic              dev_bcast,
   input  logic              glob_iwa_en,
   input  logic              glob_ixeqz_en,
   input  logic              pend_clr_wr,
   input  logic [1:0]        pend_clr_mask,
   output logic [1:0]        pend_q,
   output logic              irq_msg,
   output logic              log_wr,
   output logic [1:0]        log_code
);

   localparam logic [SA_W-1:0]  SA_LOW  = '0;
   localparam logic [SA_W-1:0]  SA_HIGH = '1;
   localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

   if (SA_W < 1) begin : g_bad_sa
      $error("mcd_ctrl_reg: SA_W must be at least 1");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("mcd_ctrl_reg: IDX_W must be at least 1");
   end

   logic              cmd_hit;
   logic              idx_to_zero;
   logic [WORD_W-1:0] host_q;
   logic              st_dbac, st_dpb, st_bcast, st_idxz;
   logic [NUM_EVT-1:0] ev_word_en, ev_glob_en, ev_cond;

   assign cmd_hit = dev_done & exec_en & ~dev_tr &
                    ((dev_sa == SA_LOW) | (dev_sa == SA_HIGH));

   assign idx_to_zero = dev_indexed & (dev_idx_pre == IDX_ONE) &
                        (dev_idx_post == '0);

   mcd_host_field #(.W(WORD_W)) u_host (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_wr),
      .exec_en (exec_en),
      .wdata   (host_wdata),
      .q       (host_q)
   );

   mcd_dev_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_rst   (sw_rst),
      .hit      (cmd_hit),
      .host_rd  (host_rd),
      .dpb_in   (dev_dpb),
      .bcast_in (dev_bcast),
      .idxz_in  (idx_to_zero),
      .dbac     (st_dbac),
      .dpb      (st_dpb),
      .bcast    (st_bcast),
      .idxz     (st_idxz)
   );

   always_comb begin
      ev_word_en          = '0;
      ev_glob_en          = '0;
      ev_cond             = '0;
      ev_word_en[EVT_ACC] = host_q[POS_ACC];
      ev_word_en[EVT_IXQ] = host_q[POS_IXQ];
      ev_glob_en[EVT_ACC] = glob_iwa_en;
      ev_glob_en[EVT_IXQ] = glob_ixeqz_en;
      ev_cond[EVT_ACC]    = 1'b1;
      ev_cond[EVT_IXQ]    = idx_to_zero;
   end

   mcd_irq_qual #(.NEV(NUM_EVT)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_hit  (cmd_hit),
      .word_en  (ev_word_en),
      .glob_en  (ev_glob_en),
      .cond     (ev_cond),
      .clr_wr   (pend_clr_wr),
      .clr_mask (pend_clr_mask),
      .pend     (pend_q),
      .irq      (irq_msg),
      .log_wr   (log_wr),
      .log_code (log_code)
   );

   always_comb begin
      host_rdata            = host_q;
      host_rdata[POS_DBAC]  = st_dbac;
      host_rdata[POS_DPB]   = st_dpb;
      host_rdata[POS_BCAST] = st_bcast;
      host_rdata[POS_IDXZ]  = st_idxz;
   end

endmodule

// File: rtl/mcd_ctrl_reg_chk.sv
module mcd_ctrl_reg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        exec_en,
   input logic        sw_rst,
   input logic        host_wr,
   input logic        host_rd,
   input logic        cmd_hit,
   input logic [15:0] host_rdata,
   input logic        glob_iwa_en,
   input logic        pend_clr_wr,
   input logic        irq_msg,
   input logic        log_wr,
   input logic [1:0]  log_code
);

   AST_NO_HIT_NO_LOG: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_hit |=> !log_wr);                                             // R2
   AST_DEV_BITS_IMMUNE: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !cmd_hit && !sw_rst |=> $stable(host_rdata[10:8]));     // R3
   AST_BIT2_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && host_wr |=> $stable(host_rdata[2]));                    // R4
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> host_rdata[11:9] == 3'b000);                            // R5
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !cmd_hit && !sw_rst |=> !host_rdata[11]);               // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && !sw_rst |=> host_rdata[11]);                            // R7
   AST_IWA_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && host_rdata[14] && glob_iwa_en |=> log_wr && log_code[0]); // R8
   AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msg && !pend_clr_wr |=> irq_msg);                              // R10
   AST_LOG_SETS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      log_wr |-> irq_msg);                                               // R10

endmodule

bind mcd_ctrl_reg mcd_ctrl_reg_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exec_en     (exec_en),
   .sw_rst      (sw_rst),
   .host_wr     (host_wr),
   .host_rd     (host_rd),
   .cmd_hit     (cmd_hit),
   .host_rdata  (host_rdata),
   .glob_iwa_en (glob_iwa_en),
   .pend_clr_wr (pend_clr_wr),
   .irq_msg     (irq_msg),
   .log_wr      (log_wr),
   .log_code    (log_code)
);

// File: tb/mcd_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module mcd_ctrl_reg_tb_top;

   localparam int SA_W  = 5;
   localparam int IDX_W = 8;

   localparam int K_WORD = 0;
   localparam int K_PEND = 1;
   localparam int K_IRQ  = 2;
   localparam int K_LOG  = 3;

   typedef struct {
      string       tag;
      int          kind;
      logic [15:0] val;
   } sb_item_t;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              exec_en, sw_rst, host_rd, host_wr;
   logic [15:0]       host_wdata, host_rdata;
   logic              dev_done, dev_tr, dev_indexed, dev_dpb, dev_bcast;
   logic [SA_W-1:0]   dev_sa;
   logic [IDX_W-1:0]  dev_idx_pre, dev_idx_post;
   logic              glob_iwa_en, glob_ixeqz_en, pend_clr_wr;
   logic [1:0]        pend_clr_mask, pend_q, log_code;
   logic              irq_msg, log_wr;

   int total = 0;
   int bad   = 0;
   sb_item_t sb_q[$];

   always #10 clk = ~clk;

   mcd_ctrl_reg #(.SA_W(SA_W), .IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .sw_rst(sw_rst),
      .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .dev_done(dev_done), .dev_tr(dev_tr),
      .dev_sa(dev_sa), .dev_indexed(dev_indexed), .dev_idx_pre(dev_idx_pre),
      .dev_idx_post(dev_idx_post), .dev_dpb(dev_dpb), .dev_bcast(dev_bcast),
      .glob_iwa_en(glob_iwa_en), .glob_ixeqz_en(glob_ixeqz_en),
      .pend_clr_wr(pend_clr_wr), .pend_clr_mask(pend_clr_mask),
      .pend_q(pend_q), .irq_msg(irq_msg), .log_wr(log_wr), .log_code(log_code)
   );

   function automatic logic [15:0] observe(input int kind);
      case (kind)
         K_WORD:  return host_rdata;
         K_PEND:  return {14'd0, pend_q};
         K_IRQ:   return {15'd0, irq_msg};
         default: return {13'd0, log_wr, log_code};
      endcase
   endfunction

   task automatic check(input string tag, input int kind, input logic [15:0] exp);
      logic [15:0] got;
      got = observe(kind);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s kind=%0d actual=%h expected=%h", tag, kind, got, exp);
      end
   endtask

   task automatic expect_after_edge(input string tag, input int kind, input logic [15:0] v);
      sb_item_t it;
      it.tag  = tag;
      it.kind = kind;
      it.val  = v;
      sb_q.push_back(it);
   endtask

   // monitor: compares queued expectations midway after each rising edge
   always begin
      @(posedge clk);
      #5;
      while (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         check(it.tag, it.kind, it.val);
      end
   end

   task automatic idle();
      host_rd     = 1'b0;
      host_wr     = 1'b0;
      dev_done    = 1'b0;
      sw_rst      = 1'b0;
      pend_clr_wr = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic cmd(input logic [SA_W-1:0] sa, input logic tr, input logic ix,
                      input logic [IDX_W-1:0] pre, input logic [IDX_W-1:0] post,
                      input logic dpb, input logic bc);
      dev_done     = 1'b1;
      dev_sa       = sa;
      dev_tr       = tr;
      dev_indexed  = ix;
      dev_idx_pre  = pre;
      dev_idx_post = post;
      dev_dpb      = dpb;
      dev_bcast    = bc;
   endtask

   task automatic hwrite(input logic [15:0] d);
      host_wr    = 1'b1;
      host_wdata = d;
   endtask

   task automatic pclear(input logic [1:0] m);
      pend_clr_wr   = 1'b1;
      pend_clr_mask = m;
   endtask

   initial begin
      #(20 * 5000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; exec_en = 1'b0; glob_iwa_en = 1'b0; glob_ixeqz_en = 1'b0;
      host_wdata = '0; pend_clr_mask = '0;
      dev_sa = '0; dev_tr = 1'b0; dev_indexed = 1'b0;
      dev_idx_pre = '0; dev_idx_post = '0; dev_dpb = 1'b0; dev_bcast = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      step();  // R1 reset state
      expect_after_edge("R1 word", K_WORD, 16'h0000);
      expect_after_edge("R1 pend", K_PEND, 16'h0000);
      expect_after_edge("R1 pin",  K_IRQ,  16'h0000);
      expect_after_edge("R1 log",  K_LOG,  16'h0000);

      step();  // R4 R3: write all ones while idle
      hwrite(16'hFFFF);
      expect_after_edge("R4 R3 write all ones idle", K_WORD, 16'hF00C);

      step();  // R4: bit 2 locked while executing
      exec_en = 1'b1;
      hwrite(16'h0000);
      expect_after_edge("R4 bit2 locked", K_WORD, 16'h0004);

      step();
      hwrite(16'hFFFF);
      expect_after_edge("R4 rewrite", K_WORD, 16'hF00C);

      step();  // R2 wrong subaddress
      glob_iwa_en = 1'b1; glob_ixeqz_en = 1'b1;
      cmd(5'd5, 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b1);
      expect_after_edge("R2 sa5 word", K_WORD, 16'hF00C);
      expect_after_edge("R2 sa5 log",  K_LOG,  16'h0000);

      step();  // R2 transmit command
      cmd(5'd0, 1'b1, 1'b0, 8'd0, 8'd0, 1'b1, 1'b1);
      expect_after_edge("R2 tr1 word", K_WORD, 16'hF00C);
      expect_after_edge("R2 tr1 log",  K_LOG,  16'h0000);

      step();  // R3 R8 R9: sa 31, index 2->1
      cmd(5'd31, 1'b0, 1'b1, 8'd2, 8'd1, 1'b1, 1'b0);
      expect_after_edge("R3 status load", K_WORD, 16'hFC0C);
      expect_after_edge("R8 R9 log acc only", K_LOG, 16'h0005);
      expect_after_edge("R8 pend", K_PEND, 16'h0001);

      step();  // R6 read clear
      host_rd = 1'b1;
      #1 check("R6 read returns set bit", K_WORD, 16'hFC0C);
      expect_after_edge("R6 cleared after read", K_WORD, 16'hF40C);
      expect_after_edge("R8 log one cycle", K_LOG, 16'h0000);

      step();  // R9 index 1->0
      cmd(5'd0, 1'b0, 1'b1, 8'd1, 8'd0, 1'b0, 1'b1);
      expect_after_edge("R9 word", K_WORD, 16'hFB0C);
      expect_after_edge("R9 log both", K_LOG, 16'h0007);
      expect_after_edge("R9 pend", K_PEND, 16'h0003);

      step();  // R7 read and set together; R9 0->0 no fire
      host_rd = 1'b1;
      cmd(5'd31, 1'b0, 1'b1, 8'd0, 8'd0, 1'b0, 1'b0);
      expect_after_edge("R7 set beats read", K_WORD, 16'hF80C);
      expect_after_edge("R9 zero to zero", K_LOG, 16'h0005);

      step();  // R10 partial clear
      pclear(2'b01);
      expect_after_edge("R10 clear bit0", K_PEND, 16'h0002);
      expect_after_edge("R10 pin held", K_IRQ, 16'h0001);

      step();  // R10 set beats clear
      pclear(2'b11);
      cmd(5'd0, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0);
      expect_after_edge("R10 set beats clear", K_PEND, 16'h0001);

      step();
      pclear(2'b01);
      expect_after_edge("R10 all clear", K_PEND, 16'h0000);
      expect_after_edge("R10 pin low", K_IRQ, 16'h0000);

      step();
      cmd(5'd31, 1'b0, 1'b1, 8'd1, 8'd0, 1'b1, 1'b1);
      expect_after_edge("R3 all status", K_WORD, 16'hFF0C);

      step();  // R5 soft reset
      sw_rst = 1'b1;
      expect_after_edge("R5 soft reset", K_WORD, 16'hF10C);

      step();
      pclear(2'b11);
      expect_after_edge("R10 clear both", K_PEND, 16'h0000);

      step();  // R11 not executing
      exec_en = 1'b0;
      cmd(5'd0, 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b1);
      expect_after_edge("R11 word", K_WORD, 16'hF10C);
      expect_after_edge("R11 log",  K_LOG,  16'h0000);

      step();  // R4 bit 2 writable when idle
      hwrite(16'h0000);
      expect_after_edge("R4 idle write", K_WORD, 16'h0100);

      step();  // R8 word enable off
      exec_en = 1'b1;
      cmd(5'd0, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0);
      expect_after_edge("R8 word en off", K_WORD, 16'h0800);
      expect_after_edge("R8 no log", K_LOG, 16'h0000);

      step();
      hwrite(16'hC000);
      expect_after_edge("R4 enables set", K_WORD, 16'hC800);

      step();  // R8 R9 global enables off
      glob_iwa_en = 1'b0; glob_ixeqz_en = 1'b0;
      cmd(5'd31, 1'b0, 1'b1, 8'd1, 8'd0, 1'b0, 1'b0);
      expect_after_edge("R9 index flag", K_WORD, 16'hC900);
      expect_after_edge("R8 R9 global off", K_LOG, 16'h0000);
      expect_after_edge("R8 R9 no pend", K_PEND, 16'h0000);

      step();
      pclear(2'b00);
      step();  // R1 asynchronous master reset
      rst_n = 1'b0;
      #1;
      check("R1 word", K_WORD, 16'h0000);
      check("R1 pend", K_PEND, 16'h0000);
      check("R1 pin",  K_IRQ,  16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      step();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule